// File: doc/BRIEF.md
# Flying-Capacitor Switch-State Selector

This block chooses, once per switching period, the gate pattern for a three-capacitor, four-level flying-capacitor converter. A controller presents the capacitor-voltage error of the two inner flying capacitors (measured value minus target), the sign of the load current and the output level wanted for the coming period. The block then issues the three gate bits that the power stage applies for the whole of that period.

Levels 1 and 2 can each be produced by three different gate patterns. Each of these patterns pushes the pair of inner capacitor voltages along its own fixed direction. The block turns the error into a steering direction and inverts it when the load current is negative. It then takes, among the patterns that produce the requested level, the one whose unit direction lies at the smallest angle from that steering direction. The smallest angle is found as the largest dot product with fixed-point unit direction constants, so the block needs no divider, square root or arccos. Scaling the error by a positive factor does not change the ranking, so the error is never normalized.

Top module: `ffc_state_sel`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `gates_o` is 3'b000.
- R2: `valid_o` is high for exactly one clock in the cycle after each cycle in which `start_i` is sampled high, and is low at all other times.
- R3: The number of ones in the `gates_o` value issued with `valid_o` equals the `level_i` value (0 to 3) sampled with the matching `start_i`.
- R4: Level 0 always yields 3'b000 and level 3 always yields 3'b111, whatever the error and current sign.
- R5: `gates_o[2]`, `gates_o[1]` and `gates_o[0]` are the first, second and third gate bits. For levels 1 and 2 the chosen pattern maximizes the dot product of the steering vector (V2 error, V3 error) with the unit direction of the pattern. The unnormalized directions are: 001 (0,1), 010 (2,-1), 100 (-2,0), 011 (2,0), 101 (-2,1), 110 (0,-1).
- R6: When `cur_neg_i` is 1, both error components are negated before the comparison.
- R7: A zero error vector yields the lowest-index pattern of the requested level: 001 for level 1, 011 for level 2.
- R8: When two candidates give equal dot products, the lower pattern index wins.
- R9: Between results, `gates_o` holds the last issued pattern unchanged.
- R10: Full-scale error components, including the most negative code, are handled without overflow, with or without inversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One selection request per switching period |
| err_v2_i | input | ERR_W | Signed error of the second capacitor voltage |
| err_v3_i | input | ERR_W | Signed error of the third capacitor voltage |
| cur_neg_i | input | 1 | Load current is negative |
| level_i | input | 2 | Requested output level, 0 to 3 |
| gates_o | output | 3 | Chosen gate bits, first gate in bit 2 |
| valid_o | output | 1 | One-cycle strobe marking a new selection |

## Verification
An angle sweep drives the error around the full circle at twenty-four directions, each kept clear of the boundaries where two candidates swap. The sweep runs for levels 1 and 2 and both current signs, which checks the whole angular partition of R5 and the inversion of R6. Directed vectors cover the zero error and the exact bisectors between axis-aligned candidates, which separates the lowest-index rule from other tie orders. Full-scale and most-negative codes cover overflow. Levels 0 and 3 with large errors confirm that the error has no effect on those levels. Idle gaps between requests show that the output holds and that the strobe stays low.

// File: rtl/ffc_sel_pkg.sv
package ffc_sel_pkg;

  localparam int unsigned NUM_CAPS = 3;
  localparam int unsigned NUM_PAT  = 1 << NUM_CAPS;
  localparam int unsigned PAT_W    = NUM_CAPS;
  localparam int unsigned LVL_W    = $clog2(NUM_CAPS + 1);

  function automatic longint isqrt(input longint n);
    longint r;
    longint t;
    r = 0;
    for (int b = 31; b >= 0; b--) begin
      t = r | (longint'(1) << b);
      if (t * t <= n) r = t;
    end
    return r;
  endfunction

  // gate k (1-based) sits at bit NUM_CAPS-k of the pattern index
  function automatic int gate_bit(input int pat, input int k);
    return (pat >> (NUM_CAPS - k)) & 1;
  endfunction

  function automatic int cap_coef(input int pat, input int k);
    if (k == 1) return gate_bit(pat, 1);
    return gate_bit(pat, k) - gate_bit(pat, k - 1);
  endfunction

  function automatic int pat_level(input int pat);
    int c;
    c = 0;
    for (int k = 0; k < int'(NUM_CAPS); k++) c += (pat >> k) & 1;
    return c;
  endfunction

  // unit direction component scaled by 2^frac_w; axis 0 = V2, 1 = V3
  function automatic longint dir_comp(input int pat, input int axis,
                                      input int cap_ratio, input int frac_w);
    longint rx;
    longint ry;
    longint r;
    longint len2;
    longint mag;
    rx   = longint'(cap_ratio * cap_coef(pat, 2));
    ry   = longint'(cap_coef(pat, 3));
    len2 = rx * rx + ry * ry;
    if (len2 == 0) return 0;
    r   = (axis == 0) ? rx : ry;
    mag = isqrt(((r * r) << (2 * frac_w)) / len2);
    return (r < 0) ? -mag : mag;
  endfunction

endpackage

// File: rtl/ffc_err_cond.sv
module ffc_err_cond #(
  parameter int unsigned ERR_W = 16
) (
  input  logic signed [ERR_W-1:0] err_v2_i,
  input  logic signed [ERR_W-1:0] err_v3_i,
  input  logic                    neg_i,
  output logic signed [ERR_W:0]   ex_o,
  output logic signed [ERR_W:0]   ey_o
);
  logic signed [ERR_W:0] ex_ext;
  logic signed [ERR_W:0] ey_ext;

  // one guard bit so negating the most negative code cannot wrap
  assign ex_ext = {err_v2_i[ERR_W-1], err_v2_i};
  assign ey_ext = {err_v3_i[ERR_W-1], err_v3_i};
  assign ex_o   = neg_i ? -ex_ext : ex_ext;
  assign ey_o   = neg_i ? -ey_ext : ey_ext;
endmodule

// File: rtl/ffc_dir_dot.sv
module ffc_dir_dot
  import ffc_sel_pkg::*;
#(
  parameter int unsigned PAT       = 0,
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned FRAC_W    = 14,
  parameter int unsigned CAP_RATIO = 2,
  parameter int unsigned DOT_W     = ERR_W + FRAC_W + 4
) (
  input  logic signed [ERR_W:0]   ex_i,
  input  logic signed [ERR_W:0]   ey_i,
  output logic signed [DOT_W-1:0] dot_o
);
  localparam int unsigned K_W = FRAC_W + 2;
  localparam longint CX = dir_comp(int'(PAT), 0, int'(CAP_RATIO), int'(FRAC_W));
  localparam longint CY = dir_comp(int'(PAT), 1, int'(CAP_RATIO), int'(FRAC_W));
  localparam logic signed [K_W-1:0] KX = CX[K_W-1:0];
  localparam logic signed [K_W-1:0] KY = CY[K_W-1:0];

  logic signed [DOT_W-1:0] px;
  logic signed [DOT_W-1:0] py;

  assign px    = DOT_W'(ex_i) * DOT_W'(KX);
  assign py    = DOT_W'(ey_i) * DOT_W'(KY);
  assign dot_o = px + py;
endmodule

// File: rtl/ffc_pick.sv
module ffc_pick
  import ffc_sel_pkg::*;
#(
  parameter int unsigned DOT_W = 34
) (
  input  logic signed [DOT_W-1:0] dot_i [NUM_PAT],
  input  logic [LVL_W-1:0]        level_i,
  output logic [PAT_W-1:0]        pat_o
);
  logic [NUM_PAT-1:0] cand;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_cand
    localparam logic [LVL_W-1:0] PLVL = LVL_W'(pat_level(p));
    assign cand[p] = (PLVL == level_i);
  end

  // strict compare from index 0 upward keeps the lowest index on ties
  always_comb begin
    logic                    found;
    logic signed [DOT_W-1:0] best;
    found = 1'b0;
    best  = '0;
    pat_o = '0;
    for (int p = 0; p < int'(NUM_PAT); p++) begin
      if (cand[p] && (!found || dot_i[p] > best)) begin
        best  = dot_i[p];
        pat_o = PAT_W'(p);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ffc_state_sel.sv
module ffc_state_sel
  import ffc_sel_pkg::*;
#(
  parameter int unsigned ERR_W     = 16,
  parameter int unsigned FRAC_W    = 14,
  parameter int unsigned CAP_RATIO = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic signed [ERR_W-1:0] err_v2_i,
  input  logic signed [ERR_W-1:0] err_v3_i,
  input  logic                    cur_neg_i,
  input  logic [LVL_W-1:0]        level_i,
  output logic [PAT_W-1:0]        gates_o,
  output logic                    valid_o
);
  localparam int unsigned DOT_W = ERR_W + FRAC_W + 4;

  logic signed [ERR_W:0]   ex;
  logic signed [ERR_W:0]   ey;
  logic signed [DOT_W-1:0] dots [NUM_PAT];
  logic [PAT_W-1:0]        pat_sel;
  logic [PAT_W-1:0]        gates_q;
  logic                    valid_q;

  ffc_err_cond #(.ERR_W(ERR_W)) i_err_cond (
    .err_v2_i (err_v2_i),
    .err_v3_i (err_v3_i),
    .neg_i    (cur_neg_i),
    .ex_o     (ex),
    .ey_o     (ey)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_dot
    ffc_dir_dot #(
      .PAT       (p),
      .ERR_W     (ERR_W),
      .FRAC_W    (FRAC_W),
      .CAP_RATIO (CAP_RATIO),
      .DOT_W     (DOT_W)
    ) i_dot (
      .ex_i  (ex),
      .ey_i  (ey),
      .dot_o (dots[p])
    );
  end

  ffc_pick #(.DOT_W(DOT_W)) i_pick (
    .dot_i   (dots),
    .level_i (level_i),
    .pat_o   (pat_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gates_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) gates_q <= pat_sel;
    end
  end

  assign gates_o = gates_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ffc_state_sel_chk.sv
module ffc_state_sel_chk #(
  parameter int unsigned ERR_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic signed [ERR_W-1:0] err_v2_i,
  input logic signed [ERR_W-1:0] err_v3_i,
  input logic [1:0]              level_i,
  input logic [2:0]              gates_o,
  input logic                    valid_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_idle: assert (!valid_o && gates_o == 3'b000);
    end
  end

  a_r2_valid_follows_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  a_r2_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  a_r3_level_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ($countones(gates_o) == int'($past(level_i))));

  a_r7_zero_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && err_v2_i == '0 && err_v3_i == '0) |=>
      ({1'b0, gates_o} == ((4'd1 << $past(level_i)) - 4'd1)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(gates_o));
endmodule

bind ffc_state_sel ffc_state_sel_chk #(.ERR_W(ERR_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .err_v2_i (err_v2_i),
  .err_v3_i (err_v3_i),
  .level_i  (level_i),
  .gates_o  (gates_o),
  .valid_o  (valid_o)
);

// File: tb/test_ffc_state_sel.sv
module test_ffc_state_sel;
  localparam int ERR_W = 16;
  localparam real PI = 3.14159265358979;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    start_i = 1'b0;
  logic signed [ERR_W-1:0] err_v2_i = '0;
  logic signed [ERR_W-1:0] err_v3_i = '0;
  logic                    cur_neg_i = 1'b0;
  logic [1:0]              level_i = '0;
  logic [2:0]              gates_o;
  logic                    valid_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic [2:0] exp_q [$];
  string      tag_q [$];
  logic [2:0] last_exp = 3'b000;

  always #10 clk_i = ~clk_i;

  ffc_state_sel i_ffc_state_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .err_v2_i  (err_v2_i),
    .err_v3_i  (err_v3_i),
    .cur_neg_i (cur_neg_i),
    .level_i   (level_i),
    .gates_o   (gates_o),
    .valid_o   (valid_o)
  );

  function automatic logic [2:0] model(input int ex, input int ey, input bit neg, input int lvl);
    real x, y, dx, dy, n, d, best;
    bit found;
    logic [2:0] r;
    found = 0; best = 0.0; r = 3'b000;
    x = ex; y = ey;
    if (neg) begin x = -x; y = -y; end
    for (int p = 0; p < 8; p++) begin
      int t1, t2, t3;
      t1 = (p >> 2) & 1; t2 = (p >> 1) & 1; t3 = p & 1;
      if (t1 + t2 + t3 == lvl) begin
        dx = 2.0 * (t2 - t1);
        dy = t3 - t2;
        n = $sqrt(dx * dx + dy * dy);
        if (n > 0.0) begin dx = dx / n; dy = dy / n; end
        d = dx * x + dy * y;
        if (!found || d > best) begin
          best = d; r = 3'(p); found = 1;
        end
      end
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic issue(input int ex, input int ey, input bit neg, input int lvl, input string tag);
    @(negedge clk_i);
    err_v2_i  = ERR_W'(ex);
    err_v3_i  = ERR_W'(ey);
    cur_neg_i = neg;
    level_i   = 2'(lvl);
    start_i   = 1'b1;
    last_exp  = model(ex, ey, neg, lvl);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected strobe: actual valid 1 expected 0");
      end else begin
        string t;
        logic [2:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, gates_o, e);
      end
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles >= 100000 && !done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset gates", gates_o, 3'b000);
    check("R1 reset valid", {2'b00, valid_o}, 3'b000);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R7 zero error
    issue(0, 0, 0, 1, "R7 zero lvl1");
    issue(0, 0, 1, 2, "R7 zero lvl2 neg");
    idle(2);
    // R8 exact ties between axis-aligned candidates
    issue(-5000, 5000, 0, 1, "R8 tie 001 vs 100");
    issue(5000, -5000, 0, 2, "R8 tie 011 vs 110");
    issue(5000, -5000, 1, 1, "R8 tie neg lvl1");
    idle(1);
    // R4 extreme levels ignore error
    issue(30000, -12000, 0, 0, "R4 lvl0");
    issue(-30000, 12000, 1, 3, "R4 lvl3");
    issue(-32768, 32767, 0, 0, "R4 lvl0 full");
    idle(1);
    // R5 / R6 directed
    issue(0, 9000, 0, 1, "R5 along 001");
    issue(9000, -4500, 0, 1, "R5 along 010");
    issue(0, 9000, 1, 1, "R6 inverted 001 axis");
    issue(-9000, 4500, 0, 2, "R5 along 101");
    issue(-9000, 4500, 1, 2, "R6 inverted 101");
    // R10 full scale
    issue(-32768, -32768, 0, 1, "R10 min lvl1");
    issue(-32768, -32768, 1, 1, "R10 min lvl1 neg");
    issue(-32768, 0, 1, 2, "R10 min lvl2 neg");
    issue(32767, 32767, 0, 2, "R10 max lvl2");
    // R9 hold and no strobe while idle
    idle(6);
    check("R9 hold", gates_o, last_exp);
    check("R2 idle valid", {2'b00, valid_o}, 3'b000);

    // R5 R6 R3 angle sweep
    for (int lvl = 1; lvl <= 2; lvl++) begin
      for (int neg = 0; neg <= 1; neg++) begin
        for (int k = 0; k < 24; k++) begin
          real a;
          a = (7.0 + 15.0 * k) * PI / 180.0;
          issue($rtoi(20000.0 * $cos(a)), $rtoi(20000.0 * $sin(a)), neg[0], lvl,
                neg ? "R6 sweep neg" : "R5 sweep");
        end
        idle(1);
      end
    end
    idle(4);
    check("R9 hold after sweep", gates_o, last_exp);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R2 missing strobes: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule